// File: doc/BRIEF.md
# Diagnostic ADC conversion scheduler

This block decides what an 8-bit diagnostic successive-approximation converter measures, and when it measures it. When software has asked for nothing, the scheduler keeps the converter busy with supply-voltage conversions. It stores each supply result in its own register, so the latest supply reading is always available without a request.

Software asks for a single measurement by writing a 5-bit channel code. The write clears a done flag. The request waits for any conversion already running, then takes precedence over the next supply conversion. When the result lands, it goes to a result register and the done flag rises. A read strobe on the result register drops the flag again.

Codes 0 to NUM_OUT-1 name the driver outputs, and code NUM_OUT names the supply. For an output whose enable is set, the sample is placed a programmable time after that output's PWM on-state rises. An output that is switched off is sampled at once. Unimplemented codes finish immediately with a zero result.

Top module: `diag_adc_sched`

## Requirements
- R1: During reset, res_out, supply_out, done_flag and adc_start are all 0.
- R2: With no request pending, every conversion the scheduler starts uses channel code NUM_OUT (12 by default). Its result goes only to supply_out, in the cycle after completion.
- R3: A write of a code 0..NUM_OUT leaves done_flag at 0 from the clock edge that samples the write.
- R4: When a requested conversion completes, res_out takes adc_data and done_flag becomes 1 on the same edge. supply_out is unchanged.
- R5: A read strobe clears done_flag on the edge that samples it, unless a requested conversion completes on that same edge, in which case done_flag is 1.
- R6: A request written while a conversion runs starts after that conversion ends, before any further supply conversion, and uses the written code on adc_chan.
- R7: For an output channel whose enable is 1, the scheduler waits for a new rising edge of that channel's pwm_on. It then pulses adc_start on the (N+2)-th rising clock edge after the first edge that samples pwm_on high, where N = (dly_cfg+1)*TICK (TICK = 4 by default). Rising edges on other channels have no effect on the wait.
- R8: For an output channel whose enable is 0, the conversion starts without waiting for any pwm_on edge.
- R9: A write of a code above NUM_OUT sets res_out to 0 and done_flag to 1 on the sampling edge. No conversion of that code is ever started, and the write cancels any request not yet started.
- R10: A newer write supersedes the older request. A requested conversion in flight when the write lands has its result discarded. A request still waiting for its PWM edge or its delay is abandoned.
- R11: adc_start is a single-cycle pulse, issued only when adc_busy was low on the previous edge. A conversion is complete on the first edge that samples adc_busy low after an edge that sampled it high, and adc_data is captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Write strobe of the channel-select register |
| sel_wdata | input | CH_W | Channel code written |
| res_rd | input | 1 | Read strobe of the result register |
| dly_cfg | input | DLY_W | Sample delay setting for output channels |
| ch_en | input | NUM_OUT | Output enable per channel |
| pwm_on | input | NUM_OUT | PWM on-state per channel (asynchronous) |
| adc_start | output | 1 | Conversion start pulse to the converter core |
| adc_chan | output | CH_W | Channel for the conversion being started |
| adc_busy | input | 1 | Converter core is converting |
| adc_data | input | DW | Conversion result, valid when busy falls |
| res_out | output | DW | Result of the last requested conversion |
| supply_out | output | DW | Result of the last supply conversion |
| done_flag | output | 1 | Requested result is ready |

## Verification
The bench sends requests while a supply conversion is running. A scheduler without request priority would then start another supply conversion, and adc_chan would show the wrong code. The delayed sample is timed against the sampling edge for several delay settings. The bench also raises pwm_on before the request and toggles other channels during the wait, which exposes an off-by-one delay, a level-triggered wait, or a wrong channel index.

A second write is issued in the middle of a long conversion, and another during a PWM wait. A design that kept the stale result, or that converted the abandoned channel, would leave the wrong value in res_out. Writes of unimplemented codes catch a done flag that never rises or a zero that never appears.

// File: rtl/diag_adc_pkg.sv
package diag_adc_pkg;

    // Scheduler phases: waiting for work, waiting for a PWM rise,
    // counting the sample delay, converter running.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_HOLD = 2'd2,
        ST_CONV = 2'd3
    } sched_st_e;

endpackage

// File: rtl/diag_adc_pwm_sync.sv
module diag_adc_pwm_sync #(
    parameter int NUM_CH = 12,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] rise
);

    // Per channel: STAGES synchronizer flops plus one history flop.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [STAGES:0] sh_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[STAGES-1:0], pwm_in[i]};
            end
        end

        assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

endmodule

// File: rtl/diag_adc_dly_timer.sv
module diag_adc_dly_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/diag_adc_sched.sv
module diag_adc_sched
    import diag_adc_pkg::*;
#(
    parameter int NUM_OUT     = 12,
    parameter int CH_W        = 5,
    parameter int DW          = 8,
    parameter int DLY_W       = 4,
    parameter int TICK        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [CH_W-1:0]    sel_wdata,
    input  logic               res_rd,
    input  logic [DLY_W-1:0]   dly_cfg,
    input  logic [NUM_OUT-1:0] ch_en,
    input  logic [NUM_OUT-1:0] pwm_on,
    output logic               adc_start,
    output logic [CH_W-1:0]    adc_chan,
    input  logic               adc_busy,
    input  logic [DW-1:0]      adc_data,
    output logic [DW-1:0]      res_out,
    output logic [DW-1:0]      supply_out,
    output logic               done_flag
);

    localparam int CH_SPACE = 2 ** CH_W;
    localparam int MAX_WAIT = (2 ** DLY_W) * TICK;
    localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
    localparam logic [CH_W-1:0] SUP_CH = CH_W'(NUM_OUT);

    typedef struct packed {
        sched_st_e       st;
        logic            pend_v;
        logic [CH_W-1:0] pend_ch;
        logic [CH_W-1:0] cur_ch;
        logic            cur_man;
        logic            stale;
        logic            start;
        logic [CH_W-1:0] chan;
        logic [DW-1:0]   res;
        logic [DW-1:0]   sup;
        logic            done;
        logic            busy;
    } sched_t;

    sched_t q, d;

    logic [NUM_OUT-1:0]  rise;
    logic [CH_SPACE-1:0] en_ext;
    logic [CH_SPACE-1:0] rise_ext;
    logic                tmr_load;
    logic                tmr_expired;
    logic [CNT_W-1:0]    tmr_val;
    logic                conv_end;

    assign en_ext   = {{(CH_SPACE-NUM_OUT){1'b0}}, ch_en};
    assign rise_ext = {{(CH_SPACE-NUM_OUT){1'b0}}, rise};
    assign tmr_val  = CNT_W'((int'(dly_cfg) + 1) * TICK - 1);

    diag_adc_pwm_sync #(
        .NUM_CH (NUM_OUT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_in (pwm_on),
        .rise   (rise)
    );

    diag_adc_dly_timer #(
        .CW (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        d.busy   = adc_busy;
        tmr_load = 1'b0;
        conv_end = q.busy && !adc_busy;

        if (res_rd) begin
            d.done = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                d.stale = 1'b0;
                if (q.pend_v) begin
                    d.pend_v  = 1'b0;
                    d.cur_ch  = q.pend_ch;
                    d.cur_man = 1'b1;
                    if ((q.pend_ch < SUP_CH) && en_ext[q.pend_ch]) begin
                        d.st = ST_ARM;
                    end else begin
                        d.st    = ST_CONV;
                        d.start = 1'b1;
                        d.chan  = q.pend_ch;
                    end
                end else begin
                    d.cur_ch  = SUP_CH;
                    d.cur_man = 1'b0;
                    d.st      = ST_CONV;
                    d.start   = 1'b1;
                    d.chan    = SUP_CH;
                end
            end
            ST_ARM: begin
                if (rise_ext[q.cur_ch]) begin
                    tmr_load = 1'b1;
                    d.st     = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    d.st    = ST_CONV;
                    d.start = 1'b1;
                    d.chan  = q.cur_ch;
                end
            end
            ST_CONV: begin
                if (conv_end) begin
                    if (q.cur_man) begin
                        if (!q.stale) begin
                            d.res  = adc_data;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.sup = adc_data;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // A register write overrides everything above: it abandons a
        // waiting request, marks an in-flight request stale and
        // replaces the pending code.
        if (sel_wr) begin
            if (q.st == ST_ARM || q.st == ST_HOLD ||
                d.st == ST_ARM || d.st == ST_HOLD) begin
                d.st     = ST_IDLE;
                d.start  = 1'b0;
                tmr_load = 1'b0;
            end
            if (d.st == ST_CONV && d.cur_man) begin
                d.stale = 1'b1;
            end
            if (sel_wdata > SUP_CH) begin
                d.res    = '0;
                d.done   = 1'b1;
                d.pend_v = 1'b0;
            end else begin
                d.done    = 1'b0;
                d.pend_v  = 1'b1;
                d.pend_ch = sel_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign adc_start  = q.start;
    assign adc_chan   = q.chan;
    assign res_out    = q.res;
    assign supply_out = q.sup;
    assign done_flag  = q.done;

endmodule

// File: rtl/diag_adc_sched_chk.sv
module diag_adc_sched_chk #(
    parameter int CH_W = 5,
    parameter int DW   = 8,
    parameter int LAST = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sel_wr,
    input logic [CH_W-1:0] sel_wdata,
    input logic            res_rd,
    input logic            adc_start,
    input logic            adc_busy,
    input logic [DW-1:0]   res_out,
    input logic [DW-1:0]   supply_out,
    input logic            done_flag
);

    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r11_start_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> !$past(adc_busy));

    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (sel_wdata <= CH_W'(LAST))) |=> !done_flag);

    a_r9_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && (sel_wdata > CH_W'(LAST))) |=> (done_flag && res_out == '0));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && !sel_wr && !($past(adc_busy) && !adc_busy)) |=> !done_flag);

    a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(sel_wr) || ($past(adc_busy, 2) && !$past(adc_busy))));

    a_r2_supply_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(supply_out) |-> ($past(adc_busy, 2) && !$past(adc_busy)));

endmodule

bind diag_adc_sched diag_adc_sched_chk #(
    .CH_W (CH_W),
    .DW   (DW),
    .LAST (NUM_OUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wr     (sel_wr),
    .sel_wdata  (sel_wdata),
    .res_rd     (res_rd),
    .adc_start  (adc_start),
    .adc_busy   (adc_busy),
    .res_out    (res_out),
    .supply_out (supply_out),
    .done_flag  (done_flag)
);

// File: tb/diag_adc_sched_tb.sv
module diag_adc_sched_tb;

    localparam int NUM_OUT = 12;
    localparam int CH_W    = 5;
    localparam int DW      = 8;
    localparam int DLY_W   = 4;
    localparam int TICK    = 4;
    localparam int SUP     = NUM_OUT;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel_wr = 1'b0;
    logic [CH_W-1:0]    sel_wdata = '0;
    logic               res_rd = 1'b0;
    logic [DLY_W-1:0]   dly_cfg = '0;
    logic [NUM_OUT-1:0] ch_en = '0;
    logic [NUM_OUT-1:0] pwm_on = '0;
    logic               adc_start;
    logic [CH_W-1:0]    adc_chan;
    logic               adc_busy = 1'b0;
    logic [DW-1:0]      adc_data = '0;
    logic [DW-1:0]      res_out;
    logic [DW-1:0]      supply_out;
    logic               done_flag;

    always #5 clk = ~clk;

    diag_adc_sched #(
        .NUM_OUT (NUM_OUT), .CH_W (CH_W), .DW (DW),
        .DLY_W (DLY_W), .TICK (TICK), .SYNC_STAGES (2)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .sel_wr (sel_wr), .sel_wdata (sel_wdata),
        .res_rd (res_rd), .dly_cfg (dly_cfg), .ch_en (ch_en), .pwm_on (pwm_on),
        .adc_start (adc_start), .adc_chan (adc_chan), .adc_busy (adc_busy),
        .adc_data (adc_data), .res_out (res_out), .supply_out (supply_out),
        .done_flag (done_flag)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    function automatic int conv_val(input int ch, input int s);
        return (ch * 37 + s * 11 + 9) % 256;
    endfunction

    // Reference model state
    int cyc = 0;
    int e_res = 0, e_sup = 0, e_done = 0;
    int pend = -1, pend_before = -1;
    bit wr_now = 0, prev_busy = 0;
    bit inflight = 0, inflight_man = 0, m_stale = 0;
    int rise_edge [NUM_OUT];
    int conv_len = 3, busy_cnt = 0, seq = 0, cur_conv_ch = 0;
    int man_starts = 0, bg_starts = 0;
    bit prev_start = 0;

    // Model update on each clock edge, in the order the requirements give
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            e_res = 0; e_sup = 0; e_done = 0; pend = -1; pend_before = -1;
            wr_now = 0; prev_busy = 0; inflight = 0; inflight_man = 0; m_stale = 0;
        end else begin
            pend_before = pend;
            wr_now = sel_wr;
            if (res_rd) e_done = 0;                          // R5
            if (prev_busy && !adc_busy && inflight) begin    // R11 completion
                if (inflight_man) begin
                    if (!m_stale) begin e_res = adc_data; e_done = 1; end   // R4, R10
                end else begin
                    e_sup = adc_data;                        // R2
                end
                inflight = 0;
            end else if (sel_wr && inflight && inflight_man) begin
                m_stale = 1;                                 // R10
            end
            if (sel_wr) begin
                if (int'(sel_wdata) > SUP) begin e_res = 0; e_done = 1; pend = -1; end  // R9
                else begin e_done = 0; pend = int'(sel_wdata); end                    // R3
            end
            prev_busy = adc_busy;
        end
    end

    // Compare on every clock, and act as the converter core
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(res_out) == e_res, "R4 R9 R10 res_out", int'(res_out), e_res);
            chk(int'(supply_out) == e_sup, "R2 supply_out", int'(supply_out), e_sup);
            chk(int'(done_flag) == e_done, "R3 R5 done_flag", int'(done_flag), e_done);
            if (adc_start) begin
                chk(!prev_start && !adc_busy, "R11 start pulse while idle", int'(prev_start), 0);
                chk(int'(adc_chan) <= SUP, "R9 no conversion of bad code", int'(adc_chan), SUP);
                if (pend_before >= 0) begin
                    chk(int'(adc_chan) == pend_before, "R6 requested channel first", int'(adc_chan), pend_before);
                    if (pend_before < NUM_OUT && ch_en[pend_before])
                        chk(cyc == rise_edge[pend_before] + (int'(dly_cfg) + 1) * TICK + 2,
                            "R7 delayed sample edge", cyc,
                            rise_edge[pend_before] + (int'(dly_cfg) + 1) * TICK + 2);
                    inflight_man = 1;
                    m_stale = wr_now;
                    if (!wr_now) pend = -1;
                    man_starts++;
                end else begin
                    chk(int'(adc_chan) == SUP, "R2 background channel", int'(adc_chan), SUP);
                    inflight_man = 0;
                    m_stale = 0;
                    bg_starts++;
                end
                inflight = 1;
                cur_conv_ch = int'(adc_chan);
                adc_busy = 1'b1;
                busy_cnt = conv_len;
            end else if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    seq++;
                    adc_data = DW'(conv_val(cur_conv_ch, seq));
                    adc_busy = 1'b0;
                end
            end
            prev_start = adc_start;
        end else begin
            adc_busy = 1'b0;
            busy_cnt = 0;
            prev_start = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int code);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = CH_W'(code);
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        res_rd = 1'b1;
        @(negedge clk);
        res_rd = 1'b0;
    endtask

    task automatic set_pwm(input int ch, input bit v);
        @(negedge clk);
        if (v && !pwm_on[ch]) rise_edge[ch] = cyc + 1;
        pwm_on[ch] = v;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_flag && n < 3000) begin @(negedge clk); n++; end
        chk(done_flag == 1'b1, tag, int'(done_flag), 1);
    endtask

    task automatic wait_man_start();
        int base = man_starts;
        int n = 0;
        while (man_starts == base && n < 3000) begin @(negedge clk); n++; end
    endtask

    initial begin
        for (int i = 0; i < NUM_OUT; i++) rise_edge[i] = -1000;
        tick(4);
        // R1: reset values
        chk(res_out == '0, "R1 res_out", int'(res_out), 0);
        chk(supply_out == '0, "R1 supply_out", int'(supply_out), 0);
        chk(done_flag == 1'b0, "R1 done_flag", int'(done_flag), 0);
        chk(adc_start == 1'b0, "R1 adc_start", int'(adc_start), 0);
        rst_n = 1'b1;
        tick(40);
        chk(bg_starts > 3, "R2 background conversions run", bg_starts, 4);

        // R8: disabled output channel, no PWM activity
        begin
            int base = man_starts;
            wr(3);
            wait_done("R8 R4 done after disabled channel");
            chk(man_starts == base + 1, "R8 started without pwm edge", man_starts, base + 1);
        end
        rd();   // R5
        tick(3);

        // R6: request lands during a background conversion
        begin
            int n = 0;
            while (!(adc_start && adc_chan == CH_W'(SUP)) && n < 100) begin @(negedge clk); n++; end
            wr(5);
            wait_done("R6 request served");
            rd();
        end

        // R7: enabled channel, pwm already high, other channel toggles
        ch_en[7] = 1'b1; dly_cfg = 4'd2;
        set_pwm(7, 1'b1);
        tick(4);
        wr(7);
        tick(10);
        set_pwm(7, 1'b0);
        set_pwm(2, 1'b1);
        tick(6);
        set_pwm(2, 1'b0);
        tick(3);
        set_pwm(7, 1'b1);
        wait_done("R7 delayed conversion done");
        set_pwm(7, 1'b0);
        rd();

        // R7: extreme delay settings
        ch_en[9] = 1'b1;
        foreach (dly_cfg[i]) begin end
        dly_cfg = 4'd0;
        wr(9); tick(12); set_pwm(9, 1'b1);
        wait_done("R7 minimum delay done");
        set_pwm(9, 1'b0); rd();
        dly_cfg = 4'd15;
        wr(9); tick(12); set_pwm(9, 1'b1);
        wait_done("R7 maximum delay done");
        set_pwm(9, 1'b0); rd();

        // R9: unimplemented codes complete at once
        wr(20);
        chk(done_flag && res_out == '0, "R9 code 20 immediate", int'(res_out), 0);
        rd();
        wr(31);
        chk(done_flag && res_out == '0, "R9 code 31 immediate", int'(res_out), 0);
        rd();
        tick(5);

        // R10: supersede an in-flight request
        conv_len = 20;
        wr(2);
        wait_man_start();
        tick(5);
        wr(4);
        chk(done_flag == 1'b0, "R10 done low after newer write", int'(done_flag), 0);
        wait_done("R10 newer request done");
        conv_len = 3;
        rd();
        tick(30);

        // R10: abandon a request waiting for its PWM edge
        ch_en[8] = 1'b1;
        wr(8);
        tick(8);
        wr(1);
        wait_done("R10 abandoned wait replaced");
        rd();
        tick(40);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule